// File: doc/BRIEF.md
# Two-Channel Converter Data Front End

This block sits between a digital data source and a pair of 8-bit current-steering converter cores. It turns incoming words into the two registered codes that the cores convert. Each channel holds two register stages. A write strobe loads the first stage, an input latch, from a data port. An update clock then copies that latch into the second stage, the converter code register. Because of this, a new word can be written while the previous one is still being converted.

A static mode input picks one of two ways of feeding data. In dual-port mode, each channel has its own data port, its own write strobe and its own update clock, and the two channels run apart from each other. In interleaved mode, only port A carries data, as alternating I and Q words. The port B write strobe becomes a steering select. The port B update clock becomes a resync input. The port A update clock is divided by two internally, and both code registers load together on every second accepted edge.

All inputs are sampled in one synchronous clock domain. Rising edges of the strobe and clock inputs are found by comparing each input with a registered copy of itself. The mode may only change while reset is asserted.

Top module: `dacif_front`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a clock edge, both input latches, both code outputs, the stored previous level of every strobe and clock input, and the divide-by-two phase are all cleared to 0. The outputs read 0 from the following cycle on.
- R2: In dual-port mode (`dual_mode` = 1), a rising edge of `a_wr` loads `a_data` into the channel 1 input latch, and a rising edge of `b_wr` loads `b_data` into the channel 2 input latch.
- R3: In dual-port mode, a rising edge of `a_upd` copies the channel 1 input latch to `ch1_code`, and the new value shows one cycle after the edge is sampled.
- R4: In dual-port mode, channel 2 is updated only by a rising edge of `b_upd`. Activity on `a_wr` and `a_upd` leaves `ch2_code` and its latch untouched, and the reverse holds for channel 1.
- R5: Only a 0-to-1 transition of a strobe or clock input acts. Holding the input high for several cycles gives a single action.
- R6: When a write edge and an update edge of the same channel are sampled in the same cycle, the code register takes the value the latch held before that write. The newly written word reaches the output only at a later update edge.
- R7: In interleaved mode (`dual_mode` = 0), a rising edge of `a_wr` loads `a_data` into the channel 1 latch when `b_wr` (select) is 1, and into the channel 2 latch when select is 0. The other latch keeps its value, and `b_data` has no effect.
- R8: In interleaved mode, while `b_upd` (resync) is high, rising edges of `a_upd` are ignored, both code outputs hold, and the divide-by-two phase returns to its first state.
- R9: In interleaved mode with resync low, the first accepted rising edge of `a_upd` after reset or after resync loads both code registers together from their latches. After that, only every second accepted edge loads them, so both outputs update at half the rate of the `a_upd` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_mode | input | 1 | 1 = dual-port, 0 = interleaved; change only under reset |
| a_data | input | 8 | Port A data word (interleaved stream in interleaved mode) |
| b_data | input | 8 | Port B data word (unused in interleaved mode) |
| a_wr | input | 1 | Port A write strobe; shared interleave write strobe |
| a_upd | input | 1 | Channel 1 update clock; interleave update clock |
| b_upd | input | 1 | Channel 2 update clock; interleave resync (high = hold) |
| b_wr | input | 1 | Port B write strobe; interleave steering select |
| ch1_code | output | 8 | Registered code for converter core 1 |
| ch2_code | output | 8 | Registered code for converter core 2 |

## Verification
Two functions can fall in the same cycle: a write edge that loads a channel's input latch, and an update edge that copies that same latch into the code register. In interleaved mode, a write steered to a channel can also land on the same edge as the paired load. The bench provokes both cases by sweeping every ordered pair of strobe and clock patterns in dual-port mode, and by running a pseudo-random interleaved stream in which writes, updates and a mid-stream resync coincide. In each case it judges the outputs against a bench model in which the code register always takes the latch contents from before the write (R6).

// File: rtl/dacif_pkg.sv
// Package dacif_pkg
// Shared types for the converter data front end: the mode encoding and the
// bundle of strobe and clock inputs that the edge detector watches.
package dacif_pkg;

    // Operating mode; the encoding matches the level on the mode input.
    typedef enum logic {
        MODE_IL   = 1'b0,   // one interleaved stream on port A
        MODE_DUAL = 1'b1    // two independent ports
    } dac_mode_e;

    // Number of converter channels served by the block.
    localparam int NUM_CH = 2;

    // Strobe and clock inputs whose rising edges are detected.
    typedef struct packed {
        logic upd_b;    // channel 2 update clock / interleave resync
        logic wr_b;     // port B write strobe / interleave select
        logic upd_a;    // channel 1 update clock / interleave update clock
        logic wr_a;     // port A write strobe / interleave write strobe
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/dacif_edge.sv
// Module dacif_edge
// Finds the rising edges of N level inputs. Each input is compared with a
// registered copy of itself; rise[i] is high in the cycle where the input is
// 1 and its registered copy is 0.
// Assumes: inputs are already synchronous to clk. The registered copies are
// cleared by reset, so an input that is high right after reset counts as a rise.
module dacif_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    // Keep the level of each input from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // One rising-edge detector per input.
    for (genvar g = 0; g < N; g++) begin : g_rise
        assign rise[g] = lvl[g] & ~prev_q[g];
    end

    // R5: a rise is never reported in two adjacent cycles.
    p_single_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/dacif_inlatch.sv
// Module dacif_inlatch
// Holds the input latch of each channel. In dual-port mode each latch has its
// own port and write edge. In interleaved mode a single write edge loads port
// A into the latch picked by the select level (1 = channel 1, 0 = channel 2).
// Assumes: the mode is static outside reset.
module dacif_inlatch
    import dacif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  dac_mode_e     mode,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] b_data,
    input  logic          wr_a_rise,
    input  logic          wr_b_rise,
    input  logic          sel_lvl,
    output logic [DW-1:0] lat_a,
    output logic [DW-1:0] lat_b
);

    logic          cap_a;
    logic          cap_b;
    logic [DW-1:0] src_b;

    // Pick the capture enables and the source of latch B for the current mode.
    always_comb begin
        if (mode == MODE_DUAL) begin
            cap_a = wr_a_rise;
            cap_b = wr_b_rise;
            src_b = b_data;
        end else begin
            cap_a = wr_a_rise &  sel_lvl;
            cap_b = wr_a_rise & ~sel_lvl;
            src_b = a_data;
        end
    end

    // Channel 1 input latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     lat_a <= '0;
        else if (cap_a) lat_a <= a_data;
    end

    // Channel 2 input latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     lat_b <= '0;
        else if (cap_b) lat_b <= src_b;
    end

    // R7: a write steered to channel 1 leaves channel 2's latch alone.
    p_steer_ch1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IL && wr_a_rise && sel_lvl) |=> $stable(lat_b));

    // R7: a write steered to channel 2 leaves channel 1's latch alone.
    p_steer_ch2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IL && wr_a_rise && !sel_lvl) |=> $stable(lat_a));

endmodule

// File: rtl/dacif_updctl.sv
// Module dacif_updctl
// Produces the per-channel load enables for the code registers. Dual-port:
// each channel loads on its own update edge. Interleaved: a resync level
// blocks update edges and clears a divide-by-two phase; accepted edges toggle
// the phase, and only edges found in phase 0 load both channels together.
// Assumes: the mode is static outside reset.
module dacif_updctl
    import dacif_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dac_mode_e mode,
    input  logic      upd_a_rise,
    input  logic      upd_b_rise,
    input  logic      resync_lvl,
    output logic      ld_a,
    output logic      ld_b
);

    logic half_q;
    logic acc_rise;

    // An interleave update edge counts only while resync is low.
    assign acc_rise = upd_a_rise & ~resync_lvl;

    // Divide-by-two phase of the interleave update clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                  half_q <= 1'b0;
        else if (mode != MODE_IL)    half_q <= 1'b0;
        else if (resync_lvl)         half_q <= 1'b0;
        else if (upd_a_rise)         half_q <= ~half_q;
    end

    // Load enables for the two code registers.
    always_comb begin
        if (mode == MODE_DUAL) begin
            ld_a = upd_a_rise;
            ld_b = upd_b_rise;
        end else begin
            ld_a = acc_rise & ~half_q;
            ld_b = acc_rise & ~half_q;
        end
    end

    // R9: every accepted interleave edge flips the phase.
    p_phase_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IL && acc_rise) |=> (half_q != $past(half_q)));

    // R8: resync always returns the phase to its first state.
    p_resync_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IL && resync_lvl) |=> !half_q);

endmodule

// File: rtl/dacif_front.sv
// Module dacif_front (top)
// Digital front end of a two-channel converter: edge detection on the strobe
// and clock inputs, double-buffered channel storage, and mode-dependent
// routing and update control.
// Assumes: every input is synchronous to clk; dual_mode changes only while
// rst_n is low.
module dacif_front
    import dacif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dual_mode,
    input  logic [DW-1:0] a_data,
    input  logic [DW-1:0] b_data,
    input  logic          a_wr,
    input  logic          a_upd,
    input  logic          b_upd,
    input  logic          b_wr,
    output logic [DW-1:0] ch1_code,
    output logic [DW-1:0] ch2_code
);

    dac_mode_e              mode;
    strobe_t                lvl;
    strobe_t                rise;
    logic [DW-1:0]          lat [NUM_CH];
    logic [DW-1:0]          code_q [NUM_CH];
    logic [NUM_CH-1:0]      ld;

    assign mode = dac_mode_e'(dual_mode);

    // Gather the strobe and clock levels into one bundle.
    always_comb begin
        lvl.wr_a  = a_wr;
        lvl.upd_a = a_upd;
        lvl.wr_b  = b_wr;
        lvl.upd_b = b_upd;
    end

    dacif_edge #(.N(STROBE_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .rise  (rise)
    );

    dacif_inlatch #(.DW(DW)) u_inlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .a_data    (a_data),
        .b_data    (b_data),
        .wr_a_rise (rise.wr_a),
        .wr_b_rise (rise.wr_b),
        .sel_lvl   (b_wr),
        .lat_a     (lat[0]),
        .lat_b     (lat[1])
    );

    dacif_updctl u_updctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .upd_a_rise (rise.upd_a),
        .upd_b_rise (rise.upd_b),
        .resync_lvl (b_upd),
        .ld_a       (ld[0]),
        .ld_b       (ld[1])
    );

    // One code register per channel, loaded from that channel's latch.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_code
        always_ff @(posedge clk) begin
            if (!rst_n)    code_q[c] <= '0;
            else if (ld[c]) code_q[c] <= lat[c];
        end
    end

    assign ch1_code = code_q[0];
    assign ch2_code = code_q[1];

    // R1: reset leaves both outputs at zero.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (ch1_code == '0 && ch2_code == '0));

    // R4: in dual-port mode channel 2 moves only on its own update edge.
    p_dual_isolate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DUAL && !rise.upd_b) |=> $stable(ch2_code));

    // R8: while resync is high both outputs hold.
    p_resync_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IL && b_upd) |=> ($stable(ch1_code) && $stable(ch2_code)));

endmodule

// File: tb/dacif_front_test.sv
// Bench for dacif_front: directed sequences, an exhaustive sweep of ordered
// strobe-pattern pairs in dual-port mode and a pseudo-random interleaved
// stream, all checked every cycle against a model written from the brief.
module dacif_front_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dual_mode = 1'b1;
    logic [7:0] a_data = '0;
    logic [7:0] b_data = '0;
    logic       a_wr = 1'b0;
    logic       a_upd = 1'b0;
    logic       b_upd = 1'b0;
    logic       b_wr = 1'b0;
    logic [7:0] ch1_code;
    logic [7:0] ch2_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string req = "R1";

    // Model state.
    logic [7:0] m_l1 = '0, m_l2 = '0, m_c1 = '0, m_c2 = '0;
    logic       m_ph = 1'b0;
    logic [3:0] m_prev = '0;   // {b_upd, b_wr, a_upd, a_wr}

    always #2.5 clk = ~clk;

    dacif_front uut (
        .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode),
        .a_data(a_data), .b_data(b_data),
        .a_wr(a_wr), .a_upd(a_upd), .b_upd(b_upd), .b_wr(b_wr),
        .ch1_code(ch1_code), .ch2_code(ch2_code)
    );

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus at the falling edge, advance the model at
    // the rising edge, then compare at the next falling edge.
    task automatic step(input logic [3:0] pat, input logic [7:0] da, input logic [7:0] db);
        logic [3:0] rs;
        a_wr = pat[0]; a_upd = pat[1]; b_wr = pat[2]; b_upd = pat[3];
        a_data = da; b_data = db;
        @(posedge clk);
        rs = pat & ~m_prev;
        if (!rst_n) begin
            m_l1 = '0; m_l2 = '0; m_c1 = '0; m_c2 = '0; m_ph = 1'b0; m_prev = '0;
        end else begin
            if (dual_mode) begin
                if (rs[1]) m_c1 = m_l1;        // old latch value (R6)
                if (rs[3]) m_c2 = m_l2;
                if (rs[0]) m_l1 = da;
                if (rs[2]) m_l2 = db;
            end else begin
                if (pat[3]) m_ph = 1'b0;        // resync (R8)
                else if (rs[1]) begin
                    if (!m_ph) begin m_c1 = m_l1; m_c2 = m_l2; end
                    m_ph = ~m_ph;
                end
                if (rs[0]) begin
                    if (pat[2]) m_l1 = da; else m_l2 = da;
                end
            end
            m_prev = pat;
        end
        @(negedge clk);
        check("ch1_code", ch1_code, m_c1);
        check("ch2_code", ch2_code, m_c2);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0;
        dual_mode = mode;
        req = "R1";
        step(4'b0000, 8'hFF, 8'hFF);
        step(4'b0000, 8'hFF, 8'hFF);
        check("ch1_code reset", ch1_code, 8'h00);
        check("ch2_code reset", ch2_code, 8'h00);
        rst_n = 1'b1;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        @(negedge clk);
        do_reset(1'b1);

        // R2, R3: write port A then update channel 1; explicit values.
        req = "R2";
        step(4'b0001, 8'h5A, 8'h00);
        step(4'b0000, 8'h00, 8'h00);
        req = "R3";
        step(4'b0010, 8'h00, 8'h00);
        check("R3 ch1 explicit", ch1_code, 8'h5A);
        check("R4 ch2 untouched", ch2_code, 8'h00);
        step(4'b0000, 8'h00, 8'h00);

        // R4: channel 2 on its own strobes.
        req = "R4";
        step(4'b0100, 8'h11, 8'hC3);
        step(4'b1000, 8'h22, 8'h00);
        check("R4 ch2 explicit", ch2_code, 8'hC3);
        check("R4 ch1 kept", ch1_code, 8'h5A);
        step(4'b0000, 8'h00, 8'h00);

        // R5: held strobe writes only once.
        req = "R5";
        step(4'b0001, 8'h33, 8'h00);
        step(4'b0001, 8'h44, 8'h00);
        step(4'b0001, 8'h55, 8'h00);
        step(4'b0000, 8'h00, 8'h00);
        step(4'b0010, 8'h00, 8'h00);
        check("R5 ch1 first word", ch1_code, 8'h33);
        step(4'b0000, 8'h00, 8'h00);

        // R6: simultaneous write and update of channel 1.
        req = "R6";
        step(4'b0011, 8'h77, 8'h00);
        check("R6 ch1 old latch", ch1_code, 8'h33);
        step(4'b0000, 8'h00, 8'h00);
        step(4'b0010, 8'h00, 8'h00);
        check("R6 ch1 new word", ch1_code, 8'h77);

        // R2..R6: every ordered pair of strobe patterns.
        req = "R6";
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 16; q++) begin
                step(4'(p), 8'(p * 16 + q), 8'(255 - p * 16 - q));
                step(4'(q), 8'(q * 16 + p), 8'(p ^ (q << 3)));
            end
        end

        // R1: reset after activity, then interleaved mode.
        do_reset(1'b0);

        // R7: steer I to channel 1, Q to channel 2; b_data is ignored.
        req = "R7";
        step(4'b0101, 8'hA1, 8'hEE);
        step(4'b0000, 8'h00, 8'hEE);
        step(4'b0001, 8'hB2, 8'hEE);
        step(4'b0000, 8'h00, 8'hEE);
        // R9: first accepted edge loads both.
        req = "R9";
        step(4'b0010, 8'h00, 8'h00);
        check("R9 ch1 first load", ch1_code, 8'hA1);
        check("R9 ch2 first load", ch2_code, 8'hB2);
        step(4'b0100, 8'h00, 8'h00);
        step(4'b0101, 8'hC3, 8'h00);
        step(4'b0000, 8'h00, 8'h00);
        step(4'b0010, 8'h00, 8'h00);   // second edge: no load
        check("R9 ch1 skipped", ch1_code, 8'hA1);
        step(4'b0000, 8'h00, 8'h00);
        step(4'b0010, 8'h00, 8'h00);   // third edge: load
        check("R9 ch1 third edge", ch1_code, 8'hC3);
        check("R9 ch2 third edge", ch2_code, 8'hB2);

        // R8: resync high blocks edges, then realigns the phase.
        req = "R8";
        step(4'b0000, 8'h00, 8'h00);
        step(4'b0010, 8'h00, 8'h00);   // fourth edge: no load, phase 1 -> 0
        step(4'b0000, 8'h00, 8'h00);
        step(4'b0010, 8'h00, 8'h00);   // load; phase now 1
        step(4'b0101, 8'h9D, 8'h00);
        step(4'b1000, 8'h00, 8'h00);
        step(4'b1010, 8'h00, 8'h00);
        check("R8 ch1 held", ch1_code, 8'hC3);
        step(4'b0000, 8'h00, 8'h00);
        step(4'b0010, 8'h00, 8'h00);   // first edge after resync loads
        check("R8 ch1 after resync", ch1_code, 8'h9D);

        // R7, R8, R9: pseudo-random interleaved stream with a mid-stream resync.
        req = "R9";
        for (int i = 0; i < 2000; i++) begin
            logic [3:0] pat;
            lfsr = nxt(lfsr);
            pat = {(i > 900 && i < 930) || (lfsr[7:4] == 4'h0), lfsr[2], lfsr[1], lfsr[0]};
            step(pat, lfsr[15:8], ~lfsr[7:0]);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule